// File: doc/BRIEF.md
# Multi-Channel Match-Driven PWM Timer

This block produces six pulse-width-modulated outputs from one shared up-counter. The counter advances once per prescaled tick of the clock. Seven compare registers are checked against it on every tick. Compare register 0 normally ends the cycle by returning the counter to zero. The other six compare registers place the output edges. Each output can run in one of two modes. In single-edge mode it rises at the cycle boundary and falls at its own compare value. In double-edge mode it rises at one compare value and falls at another, so the pulse can be positive or negative.

Each compare register also carries three independent actions: raise an interrupt, clear the counter, or halt the counter. Every compare hit leaves a sticky flag behind. Software programs the block through a write-only port that takes an address, data and a strobe. Compare values are written into shadow copies. The shadow copies reach the comparators only at a cycle boundary, so a period never mixes old and new settings.

Top module: `mrpwm_timer`

## Requirements
- R1: After reset the counter reads 0 and stays there, all six outputs are low, all seven flags are clear and `irq` is low.
- R2: Address 8 holds the prescale value P. Address 7 holds the control bits: bit 0 is run and bit 1 is hold. With run set and hold clear, `count_value` advances by one every P+1 clocks.
- R3: Address 9 holds 3 action bits per compare register k: bit 3k enables the interrupt, bit 3k+1 enables reset and bit 3k+2 enables stop. A tick that finds the counter equal to a compare register with reset enabled makes the count 0, so compare register 0 with reset gives a period of MR0+1 ticks. Any other compare register with reset enabled shortens the cycle in the same way.
- R4: A tick that finds the counter equal to a compare register with stop enabled, and no reset hit, leaves the count at that value and clears the run bit.
- R5: In single-edge mode output k (k = 0..5) goes high on the tick where the counter equals MR0, and goes low on the tick where it equals MR(k+1). Once running, the output is high exactly while `count_value` lies in 0..MR(k+1).
- R6: A single-edge output whose compare value equals MR0 stays low. One whose compare value exceeds MR0 stays high.
- R7: Address 10 bit k (k = 1..5) selects double-edge mode for output k. In that mode the output goes high on a match of MRk and low on a match of MR(k+1), which gives a positive pulse when MRk < MR(k+1) and a negative pulse otherwise. Bit 0 is ignored, so output 0 is always single-edge.
- R8: When an output's rising and falling matches land on the same tick, the falling match wins.
- R9: Address 10 bit 8+k enables output k. A disabled output is held low.
- R10: Writes to addresses 0..6 change a shadow copy only. The shadow copies are moved into the comparators on a tick that matches MR0, and continuously while the hold bit is set.
- R11: Every compare hit sets its flag, bit k of `match_flags`, until software writes a 1 to bit k at address 11. `irq` is high when any flag whose interrupt bit is enabled is set.
- R12: While the hold bit is set, the counter and prescaler are held at zero and no compare hits occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| count_value | output | CNT_W | Current counter value |
| pwm_out | output | 6 | PWM outputs |
| match_flags | output | 7 | Sticky per-compare hit flags |
| irq | output | 1 | Interrupt request |

## Verification
The checks that run on every cycle cover the counter arithmetic: a plain increment on an ordinary tick, a return to zero after a reset hit, a freeze together with a cleared run bit after a stop hit, and zero with no hits under hold. They also check that the comparator values move only on a load event and that flags stay set until a one is written to clear them. Only the directed scenarios can show the output waveforms: the duty and phase of single- and double-edge channels, the constant-low and constant-high corner cases, and clear-over-set priority. The scenarios also show that a mid-cycle compare write stays invisible until the next boundary, that the prescaled rate is correct, and how the interrupt line combines with the enable bits.

// File: rtl/mrpwm_pkg.sv
// Package: shared constants for the match-driven PWM timer.
// Assumes the compare registers occupy addresses 0..NUM_MATCH-1, below the control registers.
package mrpwm_pkg;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd7;
    localparam logic [ADDR_W-1:0] A_PRESC = 4'd8;
    localparam logic [ADDR_W-1:0] A_ACT   = 4'd9;
    localparam logic [ADDR_W-1:0] A_OCFG  = 4'd10;
    localparam logic [ADDR_W-1:0] A_FCLR  = 4'd11;

    localparam int unsigned CTRL_RUN_BIT  = 0;
    localparam int unsigned CTRL_HOLD_BIT = 1;
    localparam int unsigned OCFG_EN_LSB   = 8;
    localparam int unsigned ACT_STRIDE    = 3;

    // Decoded per-compare action bits.
    typedef struct packed {
        logic stop;
        logic rst;
        logic irq;
    } match_act_t;
endpackage

// File: rtl/mrpwm_regs.sv
// Module: register file for the PWM timer.
// Holds the shadow and active compare values, control, prescale, actions and output configuration.
// Assumes one write per cycle. When a stop hit and a control write land in the same cycle, the stop wins for the run bit.
module mrpwm_regs
    import mrpwm_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PS_W      = 16,
    parameter int unsigned NUM_MATCH = 7
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic                                stop_hit,
    input  logic                                mr0_hit,
    output logic                                run,
    output logic                                hold,
    output logic [PS_W-1:0]                     prescale,
    output logic [NUM_MATCH-1:0][CNT_W-1:0]     mr_act,
    output logic [NUM_MATCH-1:0]                act_irq,
    output logic [NUM_MATCH-1:0]                act_rst,
    output logic [NUM_MATCH-1:0]                act_stop,
    output logic [NUM_MATCH-2:1]                dbl_sel,
    output logic [NUM_MATCH-2:0]                out_en,
    output logic [NUM_MATCH-1:0]                flag_clr,
    output logic                                load
);
    localparam int unsigned NUM_OUT = NUM_MATCH - 1;
    localparam int unsigned ACT_W   = ACT_STRIDE * NUM_MATCH;

    logic [NUM_MATCH-1:0][CNT_W-1:0] mr_shadow;
    logic [ACT_W-1:0]                act_q;
    logic                            unused_wdata;

    assign unused_wdata = ^wr_data;
    assign load         = hold | mr0_hit;

    // Capture compare-value writes into the shadow copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr_shadow <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_MATCH; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    mr_shadow[i] <= wr_data[CNT_W-1:0];
                end
            end
        end
    end

    // Move the shadow copies into the comparators at a cycle boundary or under hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr_act <= '0;
        end else if (load) begin
            mr_act <= mr_shadow;
        end
    end

    // Control bits. A stop hit clears run after any same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            hold <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) begin
                run  <= wr_data[CTRL_RUN_BIT];
                hold <= wr_data[CTRL_HOLD_BIT];
            end
            if (stop_hit) begin
                run <= 1'b0;
            end
        end
    end

    // Prescale, action and output configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale <= '0;
            act_q    <= '0;
            dbl_sel  <= '0;
            out_en   <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_PRESC) prescale <= wr_data[PS_W-1:0];
            if (wr_addr == A_ACT)   act_q    <= wr_data[ACT_W-1:0];
            if (wr_addr == A_OCFG) begin
                dbl_sel <= wr_data[NUM_OUT-1:1];
                out_en  <= wr_data[OCFG_EN_LSB +: NUM_OUT];
            end
        end
    end

    // Split the packed action word into per-compare action fields.
    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_act
        match_act_t fld;
        assign fld         = act_q[ACT_STRIDE*g +: ACT_STRIDE];
        assign act_irq[g]  = fld.irq;
        assign act_rst[g]  = fld.rst;
        assign act_stop[g] = fld.stop;
    end

    // Write-one-to-clear mask for the hit flags.
    assign flag_clr = (wr_en && wr_addr == A_FCLR) ? wr_data[NUM_MATCH-1:0] : '0;
endmodule

// File: rtl/mrpwm_counter.sv
// Module: prescaler, shared up-counter and the seven comparators.
// A hit is taken on a prescaled tick whose current count equals an active compare value.
// Assumes reset has priority over stop when both hit on the same tick.
module mrpwm_counter #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PS_W      = 16,
    parameter int unsigned NUM_MATCH = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            run,
    input  logic                            hold,
    input  logic [PS_W-1:0]                 prescale,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] mr_act,
    input  logic [NUM_MATCH-1:0]            act_rst,
    input  logic [NUM_MATCH-1:0]            act_stop,
    output logic                            tick,
    output logic [NUM_MATCH-1:0]            match_vec,
    output logic                            stop_hit,
    output logic [CNT_W-1:0]                count
);
    logic [PS_W-1:0] pre_q;
    logic            reset_hit;

    assign tick = run & ~hold & (pre_q == prescale);

    // One comparator per compare register, qualified by the tick.
    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
        assign match_vec[g] = tick & (count == mr_act[g]);
    end

    assign reset_hit = |(match_vec & act_rst);
    assign stop_hit  = |(match_vec & act_stop);

    // Prescaler: counts clocks and wraps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Main counter: clears, holds or advances on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            count <= '0;
        end else if (tick) begin
            if (reset_hit) begin
                count <= '0;
            end else if (!stop_hit) begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mrpwm_outputs.sv
// Module: output edge logic, hit flags and interrupt request.
// Output k falls on a hit of compare k+1. It rises on a hit of compare 0 (single-edge) or of compare k (double-edge).
// Assumes a fall wins over a rise on the same tick, and a new hit wins over a same-cycle flag clear.
module mrpwm_outputs #(
    parameter int unsigned NUM_MATCH = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_MATCH-1:0] match_vec,
    input  logic [NUM_MATCH-2:1] dbl_sel,
    input  logic [NUM_MATCH-2:0] out_en,
    input  logic [NUM_MATCH-1:0] act_irq,
    input  logic [NUM_MATCH-1:0] flag_clr,
    output logic [NUM_MATCH-2:0] pwm_out,
    output logic [NUM_MATCH-1:0] flags,
    output logic                 irq
);
    localparam int unsigned NUM_OUT = NUM_MATCH - 1;

    logic [NUM_OUT-1:0] lvl_q;
    logic [NUM_OUT-1:0] set_ev;
    logic [NUM_OUT-1:0] clr_ev;

    // Pick the rise and fall sources for each output.
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_edge
        if (k == 0) begin : g_fixed
            assign set_ev[k] = match_vec[0];
        end else begin : g_sel
            assign set_ev[k] = dbl_sel[k] ? match_vec[k] : match_vec[0];
        end
        assign clr_ev[k] = match_vec[k+1];
    end

    // Output level registers, with the fall taking priority over the rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            for (int k = 0; k < NUM_OUT; k++) begin
                if (clr_ev[k]) begin
                    lvl_q[k] <= 1'b0;
                end else if (set_ev[k]) begin
                    lvl_q[k] <= 1'b1;
                end
            end
        end
    end

    assign pwm_out = lvl_q & out_en;

    // Sticky hit flags, cleared by writing a one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~flag_clr) | match_vec;
        end
    end

    assign irq = |(flags & act_irq);
endmodule

// File: rtl/mrpwm_timer.sv
// Module: top level of the match-driven PWM timer.
// Connects the register file, the counter with its comparators, and the output stage.
// Assumes NUM_MATCH is at most 7, so the compare addresses stay below the control registers.
module mrpwm_timer
    import mrpwm_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PS_W      = 16,
    parameter int unsigned NUM_MATCH = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [CNT_W-1:0]      count_value,
    output logic [NUM_MATCH-2:0]  pwm_out,
    output logic [NUM_MATCH-1:0]  match_flags,
    output logic                  irq
);
    logic                            run_q;
    logic                            hold_q;
    logic [PS_W-1:0]                 prescale;
    logic [NUM_MATCH-1:0][CNT_W-1:0] mr_act;
    logic [NUM_MATCH-1:0]            act_irq;
    logic [NUM_MATCH-1:0]            act_rst;
    logic [NUM_MATCH-1:0]            act_stop;
    logic [NUM_MATCH-2:1]            dbl_sel;
    logic [NUM_MATCH-2:0]            out_en;
    logic [NUM_MATCH-1:0]            flag_clr;
    logic                            mr_load;
    logic                            tick;
    logic [NUM_MATCH-1:0]            match_vec;
    logic                            stop_hit;

    mrpwm_regs #(.CNT_W(CNT_W), .PS_W(PS_W), .NUM_MATCH(NUM_MATCH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .stop_hit (stop_hit),
        .mr0_hit  (match_vec[0]),
        .run      (run_q),
        .hold     (hold_q),
        .prescale (prescale),
        .mr_act   (mr_act),
        .act_irq  (act_irq),
        .act_rst  (act_rst),
        .act_stop (act_stop),
        .dbl_sel  (dbl_sel),
        .out_en   (out_en),
        .flag_clr (flag_clr),
        .load     (mr_load)
    );

    mrpwm_counter #(.CNT_W(CNT_W), .PS_W(PS_W), .NUM_MATCH(NUM_MATCH)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .hold      (hold_q),
        .prescale  (prescale),
        .mr_act    (mr_act),
        .act_rst   (act_rst),
        .act_stop  (act_stop),
        .tick      (tick),
        .match_vec (match_vec),
        .stop_hit  (stop_hit),
        .count     (count_value)
    );

    mrpwm_outputs #(.NUM_MATCH(NUM_MATCH)) u_outputs (
        .clk       (clk),
        .rst_n     (rst_n),
        .match_vec (match_vec),
        .dbl_sel   (dbl_sel),
        .out_en    (out_en),
        .act_irq   (act_irq),
        .flag_clr  (flag_clr),
        .pwm_out   (pwm_out),
        .flags     (match_flags),
        .irq       (irq)
    );
endmodule

// File: rtl/mrpwm_timer_chk.sv
// Module: property checker bound into mrpwm_timer.
// Watches the counter arithmetic, comparator loading and flag stickiness on every clock.
// Assumes the default parameter values of the top module.
module mrpwm_timer_chk #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned NUM_MATCH = 7
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_en,
    input logic [3:0]                      wr_addr,
    input logic [NUM_MATCH-1:0]            wr_low,
    input logic                            run,
    input logic                            hold,
    input logic                            tick,
    input logic [NUM_MATCH-1:0]            match_vec,
    input logic [NUM_MATCH-1:0]            act_rst,
    input logic [NUM_MATCH-1:0]            act_stop,
    input logic                            load,
    input logic [NUM_MATCH-1:0][CNT_W-1:0] mr_act,
    input logic [NUM_MATCH-1:0]            flags,
    input logic [CNT_W-1:0]                count
);
    logic [NUM_MATCH-1:0] clr_mask;
    logic                 any_rst;
    logic                 any_stop;

    assign clr_mask = (wr_en && wr_addr == 4'd11) ? wr_low : '0;
    assign any_rst  = |(match_vec & act_rst);
    assign any_stop = |(match_vec & act_stop);

    // R2: an ordinary tick advances the counter by one.
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !any_rst && !any_stop) |=> count == $past(count) + CNT_W'(1));

    // R2: without a tick and without hold the counter holds its value.
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !hold) |=> $stable(count));

    // R3: a reset hit returns the counter to zero.
    a_r3_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |=> count == '0);

    // R4: a stop hit freezes the counter and drops the run bit.
    a_r4_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (any_stop && !any_rst) |=> ($stable(count) && !run));

    // R10: the comparator values move only on a load event.
    a_r10_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mr_act));

    // R11: a hit leaves its flag set.
    a_r11_flag_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (|match_vec) |=> ((flags & $past(match_vec)) == $past(match_vec)));

    // R11: a set flag stays set unless a one is written to clear it.
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(flags) & ~$past(clr_mask)) & ~flags) == '0));

    // R12: hold forces the counter to zero and blocks every hit.
    a_r12_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> count == '0);

    a_r12_hold_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> match_vec == '0);
endmodule

bind mrpwm_timer mrpwm_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_low    (wr_data[6:0]),
    .run       (run_q),
    .hold      (hold_q),
    .tick      (tick),
    .match_vec (match_vec),
    .act_rst   (act_rst),
    .act_stop  (act_stop),
    .load      (mr_load),
    .mr_act    (mr_act),
    .flags     (match_flags),
    .count     (count_value)
);

// File: tb/mrpwm_timer_bench.sv
// Directed bench for mrpwm_timer: one task per scenario, each checking its own results.
module mrpwm_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] count_value;
    logic [5:0]  pwm_out;
    logic [6:0]  match_flags;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int mr_b[7];
    bit dbl_b[6];
    bit en_b[6];

    always #(CLK_PERIOD/2) clk = ~clk;

    mrpwm_timer u_mrpwm_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .count_value (count_value),
        .pwm_out     (pwm_out),
        .match_flags (match_flags),
        .irq         (irq)
    );

    task automatic check_eq(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = 32'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_count(int v, string what);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (count_value != 16'(v) && n < 60);
        check_eq({what, " reach count"}, count_value, v);
    endtask

    // Expected level of output k at count c, derived from R5..R9.
    function automatic bit exp_out(int k, int c);
        int p, s, cl, a, d, len;
        p = mr_b[0] + 1;
        if (!en_b[k]) return 1'b0;
        s  = (k > 0 && dbl_b[k]) ? mr_b[k] : mr_b[0];
        cl = mr_b[k+1];
        if (s >= p) return 1'b0;
        if (cl >= p) return 1'b1;
        a   = (s + 1) % p;
        d   = (c - a + p) % p;
        len = (cl - s + p) % p;
        return d < len;
    endfunction

    // Halt, clear the flags, program everything, then start.
    task automatic apply(int act, int ocfg, int presc);
        wr(7, 2);
        wr(11, 'h7F);
        for (int i = 0; i < 7; i++) wr(i, mr_b[i]);
        wr(8, presc);
        wr(9, act);
        wr(10, ocfg);
        for (int k = 0; k < 6; k++) begin
            dbl_b[k] = ocfg[k];
            en_b[k]  = ocfg[8+k];
        end
        wr(7, 1);
    endtask

    task automatic window(int n, string tag);
        repeat (n) begin
            @(negedge clk);
            for (int k = 0; k < 6; k++)
                check_eq($sformatf("%s out%0d at count %0d", tag, k, count_value),
                         pwm_out[k], exp_out(k, count_value));
            check_eq({tag, " count within period"}, count_value <= 16'(mr_b[0]), 1);
        end
    endtask

    task automatic t_reset;
        check_eq("R1 count after reset", count_value, 0);
        check_eq("R1 outputs after reset", pwm_out, 0);
        check_eq("R1 flags after reset", match_flags, 0);
        check_eq("R1 irq after reset", irq, 0);
        repeat (5) @(negedge clk);
        check_eq("R1 counter halted", count_value, 0);
    endtask

    task automatic t_single;
        mr_b = '{9, 3, 0, 9, 12, 5, 5};
        apply(2, 'h2F00, 0);
        repeat (11) @(negedge clk);
        window(30, "R5/R6/R9 single-edge");
    endtask

    task automatic t_double;
        mr_b = '{9, 4, 2, 6, 7, 3, 3};
        apply(2, 'h3F37, 0);
        repeat (11) @(negedge clk);
        window(30, "R7/R8 double-edge");
    endtask

    task automatic t_prescale;
        int changes = 0;
        logic [15:0] prev;
        mr_b = '{4, 9, 9, 9, 9, 9, 9};
        apply(2, 0, 2);
        prev = count_value;
        repeat (30) begin
            @(negedge clk);
            if (count_value != prev) changes++;
            prev = count_value;
        end
        check_eq("R2 increments in 30 clocks at prescale 2", changes, 10);
    endtask

    task automatic t_shadow;
        mr_b = '{9, 3, 15, 15, 15, 15, 15};
        apply(2, 'h100, 0);
        repeat (11) @(negedge clk);
        wait_count(0, "R10");
        wr(1, 7);
        wait_count(5, "R10");
        check_eq("R10 old compare still active this period", pwm_out[0], 0);
        wait_count(0, "R10");
        wait_count(5, "R10");
        check_eq("R10 new compare active next period", pwm_out[0], 1);
        wait_count(8, "R10");
        check_eq("R10 new compare fall", pwm_out[0], 0);
    endtask

    task automatic t_stop_irq;
        mr_b = '{9, 1, 2, 5, 15, 15, 15};
        apply(2 | (1 << 9) | (1 << 11), 0, 0);
        repeat (20) @(negedge clk);
        check_eq("R4 count frozen at stop value", count_value, 5);
        repeat (8) @(negedge clk);
        check_eq("R4 count still frozen", count_value, 5);
        check_eq("R11 flags after stop", match_flags, 'h0E);
        check_eq("R11 irq from enabled flag", irq, 1);
        wr(11, 8);
        check_eq("R11 flags after clearing bit 3", match_flags, 'h06);
        check_eq("R11 irq with only unenabled flags", irq, 0);
        wr(11, 'h7F);
        check_eq("R11 flags after clearing all", match_flags, 0);
        check_eq("R4 run stays cleared", count_value, 5);
    endtask

    task automatic t_early_reset;
        int maxc = 0;
        int bad_wrap = 0;
        logic [15:0] prev;
        mr_b = '{9, 15, 6, 15, 15, 15, 15};
        apply(2 | (1 << 7), 0, 0);
        prev = count_value;
        repeat (28) begin
            @(negedge clk);
            if (int'(count_value) > maxc) maxc = int'(count_value);
            if (prev == 16'd6 && count_value != 16'd0) bad_wrap++;
            prev = count_value;
        end
        check_eq("R3 highest count with compare 2 reset", maxc, 6);
        check_eq("R3 wrap after compare 2", bad_wrap, 0);
    endtask

    task automatic t_hold;
        mr_b = '{9, 3, 15, 15, 15, 15, 15};
        apply(2, 'h100, 0);
        repeat (15) @(negedge clk);
        wr(7, 3);
        wr(11, 'h7F);
        repeat (12) @(negedge clk);
        check_eq("R12 count held at zero", count_value, 0);
        check_eq("R12 no hits under hold", match_flags, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_double();
        t_prescale();
        t_shadow();
        t_stop_irq();
        t_early_reset();
        t_hold();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule